// File: doc/BRIEF.md
# Clock-Synchronous Serial Transfer Unit

This block moves one byte at a time over a three-wire clocked serial link: a clock pin, a data output and a data input. A single shift register holds the byte. An accepted transmit item loads the register and starts a transfer. While the outgoing bits leave on the data output, the incoming bits enter the same register from the data input. There is no second buffer, so a new transmit item is refused until the current byte is complete. When the last bit has been sampled, the received byte stays on `rx_data` and `rx_valid` pulses for one cycle. That pulse serves as the interrupt request.

The unit can be the clock master or the clock slave. As master (internal clock), one of four prescaled rates of the system clock feeds an 8-bit divider, and the unit drives the clock pin. When the clock is idle it rests at a level set by the polarity bit. After the last bit, the data output keeps that bit for one more half period and then floats. A new transmit item accepted inside that window ends it at once. As slave (external clock), the clock pin passes through a two-flop synchronizer and the unit shifts on the detected transitions. Between transfers the data output drives a programmable idle level.

The transmit side is a valid/ready stream. `tx_ready` is high exactly while no transfer is in progress. An item offered while `tx_ready` is low simply waits and has no effect. The receive side has no back-pressure: `rx_valid` is a single-cycle strobe, and `rx_data` holds the byte until the next transfer starts shifting. Configuration is written through a plain write port. `cfg_sel`=0 selects the control register and `cfg_sel`=1 selects the divider. The external clock must toggle slower than one quarter of the system clock rate.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the outputs are as follows: `tx_ready`=1, `busy`=0, `rx_valid`=0, `sclk_oe`=0, `sout_oe`=1 and `sout`=0. The control register resets to external-clock mode with idle level 0.
- R2: Control register fields (`cfg_sel`=0) are:
  - bits[1:0]: prescale select, giving P = 1, 2, 8 or 32 for the values 0 to 3.
  - bit2: polarity.
  - bit3: MSB-first.
  - bit4: internal clock.
  - bit5: external-mode idle level.

  In internal mode, every half period of `sclk_out` lasts (n+1)×P system cycles, counted from the accepting edge. n is the divider register. A transfer makes 16 transitions. The clock idles high when polarity is 0.
- R3: Bit k (k = 0 to 7) on `sout` is `tx_data[k]` in LSB-first order and `tx_data[7-k]` in MSB-first order. Each new bit appears in the same cycle as the leading clock transition. With polarity 0 the leading transition is falling.
- R4: `sin` is sampled on the trailing transition. After 8 samples, `rx_data` holds the received bits, with bit k mapped to the same position as in R3.
- R5: `rx_valid` is a one-cycle pulse in the cycle of the final sampling transition. `busy` falls in that same cycle, and `tx_ready` equals the inverse of `busy`.
- R6: `tx_valid` offered while `tx_ready` is low is not accepted, and the transfer in progress continues unchanged.
- R7: In internal mode, `sout_oe` is low from the accepting edge until the first leading transition. After the final sampling transition, `sout` keeps the last bit and `sout_oe` stays high for exactly one half period.
- R8: A transmit item accepted inside that hold window drives `sout_oe` low in the next cycle.
- R9: In external mode, `sclk_oe` is 0 and `sout_oe` is 1. While idle, `sout` equals the idle-level bit. From the accepting edge, `sout` shows bit 0.
- R10: In external mode, the unit shifts on transitions of `sclk_in` within 3 system cycles. Transitions seen while idle are ignored: they cause no `rx_valid` and no change to `rx_data`.
- R11: With polarity 1, all transitions are swapped: the leading transition is rising, the sampling transition is falling, and the internal clock idles low. This applies in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control register, 1 = divider register |
| cfg_wdata | input | 8 | Configuration write data |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte can be accepted (idle) |
| tx_data | input | 8 | Byte to transmit |
| rx_valid | output | 1 | One-cycle strobe: byte received, interrupt request |
| rx_data | output | 8 | Shift register contents / received byte |
| busy | output | 1 | Transfer in progress |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock |
| sclk_oe | output | 1 | Clock pin output enable (internal mode) |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output |
| sout_oe | output | 1 | Serial data output enable (0 = high impedance) |

## Verification
The hardest state to reach is the short hold window after the final sampling transition in internal mode. A new transmit item has to land inside it for the early release of `sout_oe` to show. The stimulus therefore uses a slow clock setting with a half period of 10 cycles. It offers the next item on the very cycle the previous transfer reports completion, then checks `sout_oe` one cycle later. A second difficult point is a transmit offer made while a transfer is running. In external mode the bench drives that offer between clock transitions and then checks that the remaining output bits still follow the original byte.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int MAX_RATIO = 32;
  localparam int PCNT_W  = $clog2(MAX_RATIO);
  localparam int CTRL_W  = 6;

  // Division ratio of each prescaled source.
  function automatic int src_ratio(input int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 8;
      default: return 32;
    endcase
  endfunction

  typedef struct packed {
    logic             idle_lvl;
    logic             int_clk;
    logic             msb_first;
    logic             pol;
    logic [SEL_W-1:0] psel;
  } sio_ctrl_t;

endpackage

// File: rtl/sio_clk_div.sv
module sio_clk_div
  import sio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  output logic             half_tick
);

  logic [PCNT_W-1:0]  pcnt;
  logic [DIV_W-1:0]   dcnt;
  logic [NUM_SRC-1:0] hit;
  logic               src_tick;

  // One terminal-count comparator per prescaled source.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = (pcnt == PCNT_W'(src_ratio(g) - 1));
  end

  assign src_tick  = run && hit[sel];
  assign half_tick = src_tick && (dcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
    end else if (run) begin
      pcnt <= src_tick ? '0 : pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
    end else if (clr) begin
      dcnt <= '0;
    end else if (src_tick) begin
      dcnt <= half_tick ? '0 : dcnt + 1'b1;
    end
  end

endmodule

// File: rtl/sio_int_clock.sv
module sio_int_clock (
  input  logic clk,
  input  logic rst_n,
  input  logic pol,
  input  logic busy,
  input  logic half_tick,
  output logic sclk_lvl,
  output logic lead,
  output logic samp
);

  logic at_idle;

  // The idle level is the inverse of the polarity bit. Leaving it is the
  // leading transition; returning to it is the sampling transition.
  assign at_idle = (sclk_lvl != pol);
  assign lead    = half_tick && busy && at_idle;
  assign samp    = half_tick && busy && !at_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_lvl <= 1'b1;
    end else if (!busy) begin
      sclk_lvl <= ~pol;
    end else if (half_tick) begin
      sclk_lvl <= ~sclk_lvl;
    end
  end

endmodule

// File: rtl/sio_ext_edge.sv
module sio_ext_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic lead,
  output logic samp
);

  // [0],[1]: synchronizer chain; [2]: previous synchronized value.
  logic [2:0] sync_q;
  logic       rise;
  logic       fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin};
    end
  end

  assign rise = sync_q[1] && !sync_q[2];
  assign fall = !sync_q[1] && sync_q[2];
  assign lead = pol ? rise : fall;
  assign samp = pol ? fall : rise;

endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  logic              msb_first,
  input  logic              int_mode,
  input  logic              lead,
  input  logic              samp,
  input  logic              half_tick,
  input  logic              sin,
  output logic [DATA_W-1:0] sreg,
  output logic              sout_bit,
  output logic              busy,
  output logic              hold,
  output logic              drive,
  output logic              done
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  nbits;
  logic              last_samp;
  logic [DATA_W-1:0] shifted;
  logic              head_bit;

  assign last_samp = samp && (nbits == CNT_W'(DATA_W - 1));
  assign shifted   = msb_first ? {sreg[DATA_W-2:0], sin}
                                : {sin, sreg[DATA_W-1:1]};
  assign head_bit  = msb_first ? sreg[DATA_W-1] : sreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg     <= '0;
      sout_bit <= 1'b0;
      busy     <= 1'b0;
      hold     <= 1'b0;
      drive    <= 1'b0;
      done     <= 1'b0;
      nbits    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sreg     <= load_data;
        sout_bit <= msb_first ? load_data[DATA_W-1] : load_data[0];
        busy     <= 1'b1;
        hold     <= 1'b0;
        drive    <= 1'b0;
        nbits    <= '0;
      end else if (busy) begin
        if (lead) begin
          sout_bit <= head_bit;
          drive    <= 1'b1;
        end
        if (samp) begin
          sreg  <= shifted;
          nbits <= nbits + 1'b1;
        end
        if (last_samp) begin
          busy <= 1'b0;
          done <= 1'b1;
          hold <= int_mode;
        end
      end else if (hold && half_tick) begin
        hold  <= 1'b0;
        drive <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DIV_W-1:0]  cfg_wdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sin,
  output logic              sout,
  output logic              sout_oe
);

  sio_ctrl_t        ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             start;
  logic             half_tick;
  logic             div_run;
  logic             hold;
  logic             drive;
  logic             sout_bit;
  logic             i_lead, i_samp;
  logic             e_lead, e_samp;
  logic             lead, samp;
  logic             int_mode;
  logic             pol;
  logic             unused_cfg_hi;

  assign int_mode      = ctrl_q.int_clk;
  assign pol           = ctrl_q.pol;
  assign unused_cfg_hi = &{1'b0, cfg_wdata[DIV_W-1:CTRL_W]};

  // Configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) div_q  <= cfg_wdata;
      else         ctrl_q <= sio_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end
  end

  assign tx_ready = !busy;
  assign start    = tx_valid && tx_ready;
  assign div_run  = int_mode && (busy || hold);

  sio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start),
    .run       (div_run),
    .sel       (ctrl_q.psel),
    .div       (div_q),
    .half_tick (half_tick)
  );

  sio_int_clock u_iclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pol       (pol),
    .busy      (busy),
    .half_tick (half_tick),
    .sclk_lvl  (sclk_out),
    .lead      (i_lead),
    .samp      (i_samp)
  );

  sio_ext_edge u_eclk (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (sclk_in),
    .pol   (pol),
    .lead  (e_lead),
    .samp  (e_samp)
  );

  assign lead = int_mode ? i_lead : e_lead;
  assign samp = int_mode ? i_samp : e_samp;

  sio_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_data (tx_data),
    .msb_first (ctrl_q.msb_first),
    .int_mode  (int_mode),
    .lead      (lead),
    .samp      (samp),
    .half_tick (half_tick),
    .sin       (sin),
    .sreg      (rx_data),
    .sout_bit  (sout_bit),
    .busy      (busy),
    .hold      (hold),
    .drive     (drive),
    .done      (rx_valid)
  );

  assign sclk_oe = int_mode;
  assign sout_oe = int_mode ? drive : 1'b1;
  assign sout    = (!int_mode && !busy) ? ctrl_q.idle_lvl : sout_bit;

endmodule

// File: rtl/sio_checker.sv
module sio_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic busy,
  input logic rx_valid,
  input logic sclk_out,
  input logic sclk_oe,
  input logic sout_oe,
  input logic int_mode,
  input logic pol
);

  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_valid);

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && $past(int_mode) && !busy && $past(!busy) && $stable(pol))
      |-> (sclk_out != pol));

  // R9
  ext_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_mode |-> (sout_oe && !sclk_oe));

  // R7
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && $past(int_mode) && $rose(sout_oe)) |-> busy);

endmodule

bind sync_serial_port sio_checker u_sio_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .busy     (busy),
  .rx_valid (rx_valid),
  .sclk_out (sclk_out),
  .sclk_oe  (sclk_oe),
  .sout_oe  (sout_oe),
  .int_mode (int_mode),
  .pol      (pol)
);

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       busy;
  logic       sclk_in = 1'b1;
  logic       sclk_out;
  logic       sclk_oe;
  logic       sin = 1'b0;
  logic       sout;
  logic       sout_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sin(sin),
    .sout(sout), .sout_oe(sout_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic bit_at(input logic [7:0] d, input int k, input bit msb);
    return msb ? d[7-k] : d[k];
  endfunction

  // Monitor: compare every received byte against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "rx_valid with nothing expected", 1, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R4", "received byte", rx_data, e);
      end
    end
  end

  // All tasks start and end just after a falling clock edge.
  task automatic cfg(input bit sel, input logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ctrl(input bit intm, input bit pol, input bit msb,
                          input bit idle, input logic [1:0] psel);
    cfg(1'b0, {2'b00, idle, intm, msb, pol, psel});
    repeat (3) @(negedge clk);
  endtask

  // Driver: offer a byte, push the byte the slave will return.
  task automatic send(input logic [7:0] d, input logic [7:0] rx);
    chk(tx_ready == 1'b1, "R5", "tx_ready before offer", tx_ready, 1);
    exp_q.push_back(rx);
    tx_valid = 1'b1; tx_data = d;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(busy == 1'b1, "R5", "busy after accept", busy, 1);
  endtask

  task automatic wait_edge(output int cyc);
    logic prev;
    prev = sclk_out;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (sclk_out == prev && cyc < 1000);
  endtask

  // Slave model for internal-clock transfers.
  task automatic int_body(input logic [7:0] tx, input logic [7:0] rx,
                          input int h, input bit pol, input bit msb);
    int cyc;
    for (int i = 0; i < 16; i++) begin
      wait_edge(cyc);
      chk(cyc == h, "R2", "half period length", cyc, h);
      if (i % 2 == 0) begin
        chk(sclk_out == pol, pol ? "R11" : "R2", "leading edge level", sclk_out, pol);
        chk(sout == bit_at(tx, i / 2, msb), "R3", "transmit bit", sout, bit_at(tx, i / 2, msb));
        chk(sout_oe == 1'b1, "R7", "driven after leading edge", sout_oe, 1);
        sin = bit_at(rx, i / 2, msb);
      end else begin
        chk(sclk_out == !pol, pol ? "R11" : "R4", "sampling edge level", sclk_out, !pol);
      end
    end
    chk(busy == 1'b0, "R5", "busy at final edge", busy, 0);
    chk(tx_ready == 1'b1, "R5", "ready at final edge", tx_ready, 1);
  endtask

  task automatic hold_wait(input int h, input logic last);
    int cyc;
    cyc = 0;
    chk(sout == last, "R7", "last bit held", sout, last);
    while (sout_oe && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == h, "R7", "hold window length", cyc, h);
  endtask

  task automatic ext_xfer(input logic [7:0] tx, input logic [7:0] rx,
                          input bit pol, input bit msb, input bit idle,
                          input bit poke);
    set_ctrl(1'b0, pol, msb, idle, 2'd0);
    sclk_in = !pol;
    repeat (4) @(negedge clk);
    chk(sout == idle, "R9", "idle level", sout, idle);
    chk(sout_oe == 1'b1 && sclk_oe == 1'b0, "R9", "pin enables", {sout_oe, sclk_oe}, 2);
    send(tx, rx);
    chk(sout == bit_at(tx, 0, msb), "R9", "first bit at accept", sout, bit_at(tx, 0, msb));
    for (int k = 0; k < 8; k++) begin
      sclk_in = pol;
      repeat (6) @(negedge clk);
      chk(sout == bit_at(tx, k, msb), pol ? "R11" : "R10", "external transmit bit",
          sout, bit_at(tx, k, msb));
      sin = bit_at(rx, k, msb);
      if (poke && k == 3) begin
        tx_valid = 1'b1; tx_data = ~tx;
        chk(tx_ready == 1'b0, "R6", "not ready mid transfer", tx_ready, 0);
        @(negedge clk);
        tx_valid = 1'b0;
        @(negedge clk);
      end else begin
        repeat (2) @(negedge clk);
      end
      sclk_in = !pol;
      repeat (8) @(negedge clk);
      if (k < 7) chk(busy == 1'b1, "R10", "busy mid transfer", busy, 1);
    end
    chk(busy == 1'b0, "R10", "done after 8 samples", busy, 0);
    chk(sout == idle, "R9", "idle level after transfer", sout, idle);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    chk(sclk_oe == 1'b0, "R1", "sclk_oe", sclk_oe, 0);
    chk(sout_oe == 1'b1 && sout == 1'b0, "R1", "sout pins", {sout_oe, sout}, 2);

    // Internal clock, polarity 0, LSB first, fastest rate: half period 1.
    cfg(1'b1, 8'd0);
    set_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    chk(sclk_out == 1'b1, "R2", "idle high", sclk_out, 1);
    send(8'hA5, 8'h3C);
    chk(sout_oe == 1'b0, "R7", "floating before first edge", sout_oe, 0);
    int_body(8'hA5, 8'h3C, 1, 1'b0, 1'b0);
    hold_wait(1, 1'b1);

    // Polarity 1, MSB first, P=2, n=2: half period 6.
    cfg(1'b1, 8'd2);
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 2'd1);
    chk(sclk_out == 1'b0, "R11", "idle low", sclk_out, 0);
    send(8'h81, 8'hE7);
    chk(sout_oe == 1'b0, "R7", "floating before first edge", sout_oe, 0);
    int_body(8'h81, 8'hE7, 6, 1'b1, 1'b1);
    hold_wait(6, 1'b1);

    // Back-to-back with a write inside the hold window: half period 10.
    cfg(1'b1, 8'd4);
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b0, 2'd1);
    send(8'h5A, 8'hC3);
    int_body(8'h5A, 8'hC3, 10, 1'b0, 1'b1);
    chk(sout_oe == 1'b1, "R7", "still driving in hold", sout_oe, 1);
    send(8'h96, 8'h2D);
    chk(sout_oe == 1'b0, "R8", "write cuts hold", sout_oe, 0);
    int_body(8'h96, 8'h2D, 10, 1'b0, 1'b1);
    hold_wait(10, 1'b0);

    // Larger prescale ratios.
    cfg(1'b1, 8'd1);
    set_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2);
    send(8'hF0, 8'h0F);
    int_body(8'hF0, 8'h0F, 16, 1'b0, 1'b0);
    hold_wait(16, 1'b1);
    cfg(1'b1, 8'd0);
    set_ctrl(1'b1, 1'b1, 1'b0, 1'b0, 2'd3);
    send(8'h3C, 8'hA5);
    int_body(8'h3C, 8'hA5, 32, 1'b1, 1'b0);
    hold_wait(32, 1'b0);

    // External clock, both polarities, with an ignored offer mid transfer.
    ext_xfer(8'hC5, 8'h6B, 1'b0, 1'b0, 1'b1, 1'b1);
    ext_xfer(8'h4E, 8'hD2, 1'b1, 1'b1, 1'b0, 1'b0);

    // R10: clock transitions while idle change nothing.
    keep = rx_data;
    for (int t = 0; t < 4; t++) begin
      sclk_in = ~sclk_in;
      repeat (6) @(negedge clk);
      chk(rx_data == keep, "R10", "idle edges ignored", rx_data, keep);
      chk(busy == 1'b0, "R10", "idle edges keep idle", busy, 0);
    end

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all bytes reported", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule